// File: doc/BRIEF.md
# Per-Hart Software Interrupt Unit

This block lets one hart raise a software interrupt on another. It sits on a simple 32-bit register bus and has one 4-byte register slot for each hart. The hart index is the byte offset shifted right by two. Each slot keeps a single pending bit, and that bit drives the hart's software interrupt line as a level.

A build-time parameter picks one of two flavours. In the machine flavour a slot is an ordinary read/write bit: software writes bit 0 to raise or drop the line, and reads it back. In the supervisor flavour a slot is a doorbell. Writing a 1 sets the pending bit, writing a 0 does nothing, and a read always returns zero. The pending bit is cleared only when the hart pulses its acknowledge input after taking the interrupt.

The register window is 0x4000 bytes. An access at or beyond that offset returns an error flag and changes nothing. Every request gets its response one cycle later.

Top module: `soft_irq_unit`

## Requirements
- R1: After reset every pending bit is zero, every `irq_o` bit is low, and `rsp_valid` is low.
- R2: In the machine flavour, a write to slot i (offset 4*i, i < N_HART) stores bit 0 of the write data as the pending bit, ignores bits 31:1, and `irq_o[i]` follows the stored bit from the cycle after the write.
- R3: In the machine flavour, a read of slot i returns the pending bit in bit 0 and zeros in bits 31:1.
- R4: `rsp_valid` pulses high for exactly one cycle, in the cycle after each request, and is low in any cycle that follows a cycle without a request.
- R5: A request at offset 0x4000 or above returns `rsp_err`=1 and read data zero, and changes no pending bit, even when its low offset bits alias a valid slot.
- R6: A slot inside the window whose index is N_HART or more (this includes the reserved last slot at 0x3FFC) reads as zero, ignores writes, and returns `rsp_err`=0.
- R7: In the supervisor flavour, every in-window read returns all zeros, whatever the pending state.
- R8: In the supervisor flavour, a write with bit 0 = 1 sets the hart's pending bit, and a write with bit 0 = 0 has no effect.
- R9: In the supervisor flavour, a one-cycle pulse on `ack_i[i]` clears pending bit i. If a set and an acknowledge for the same hart arrive in the same cycle, the set wins.
- R10: In the machine flavour, `ack_i` has no effect on any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the window |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access fault: offset outside the window |
| ack_i | input | N_HART | Per-hart acknowledge that the supervisor interrupt was taken |
| irq_o | output | N_HART | Per-hart level software interrupt |

## Verification
The assertions assume three things about the inputs: each request lasts a single cycle, `req_addr` is meaningful only while `req_valid` is high, and acknowledges are single-cycle pulses. The bench keeps to all three. It drives every request for exactly one cycle on the falling clock edge, returns the strobe to zero before the next access, and raises an acknowledge for one cycle only. That includes the cycle in which an acknowledge is deliberately made to coincide with a set.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic {
        FLAVOUR_MACHINE    = 1'b0,
        FLAVOUR_SUPERVISOR = 1'b1
    } sirq_flavour_e;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } sirq_rsp_t;
endpackage

// File: rtl/sirq_decode.sv
module sirq_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned N_HART = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              out_of_window,
    output logic [N_HART-1:0] slot_hit
);
    localparam int unsigned WIN_BYTES = 32'h4000;
    localparam int unsigned IDX_W     = $clog2(WIN_BYTES) - 2;

    logic [IDX_W-1:0] slot_idx;
    logic             unused_low_bits;

    always_comb begin
        out_of_window = (32'(addr) >= WIN_BYTES);
        slot_idx      = addr[IDX_W+1:2];
    end

    assign unused_low_bits = ^addr[1:0];

    for (genvar i = 0; i < N_HART; i++) begin : g_hit
        assign slot_hit[i] = !out_of_window && (slot_idx == IDX_W'(i));
    end
endmodule

// File: rtl/sirq_slot.sv
module sirq_slot #(
    parameter sirq_pkg::sirq_flavour_e FLAVOUR = sirq_pkg::FLAVOUR_MACHINE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic ack,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (FLAVOUR == sirq_pkg::FLAVOUR_SUPERVISOR) begin
            if (ack)              pend_d = 1'b0;
            if (wr_en && wr_bit)  pend_d = 1'b1;
        end else begin
            if (wr_en)            pend_d = wr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    if (FLAVOUR == sirq_pkg::FLAVOUR_SUPERVISOR) begin : g_sup_chk
        a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && !(wr_en && wr_bit)) |=> !pend);
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_bit) |=> pend);
        a_r8_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_bit && !ack) |=> (pend == $past(pend)));
    end else begin : g_mach_chk
        logic unused_ack;
        assign unused_ack = ack;
        a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (pend == $past(wr_bit)));
        a_r10_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(pend));
    end
endmodule

// File: rtl/soft_irq_unit.sv
module soft_irq_unit #(
    parameter int unsigned             ADDR_W  = 16,
    parameter int unsigned             N_HART  = 4,
    parameter sirq_pkg::sirq_flavour_e FLAVOUR = sirq_pkg::FLAVOUR_MACHINE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [N_HART-1:0] ack_i,
    output logic [N_HART-1:0] irq_o
);
    import sirq_pkg::*;

    localparam bit IS_SUP = (FLAVOUR == FLAVOUR_SUPERVISOR);

    logic              out_of_window;
    logic [N_HART-1:0] slot_hit;
    logic [N_HART-1:0] pend;
    logic              unused_wdata;
    sirq_rsp_t         rsp_d, rsp_q;

    assign unused_wdata = ^req_wdata[31:1];

    sirq_decode #(.ADDR_W(ADDR_W), .N_HART(N_HART)) u_decode (
        .addr          (req_addr),
        .out_of_window (out_of_window),
        .slot_hit      (slot_hit)
    );

    for (genvar i = 0; i < N_HART; i++) begin : g_slot
        sirq_slot #(.FLAVOUR(FLAVOUR)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (req_valid && req_write && slot_hit[i]),
            .wr_bit (req_wdata[0]),
            .ack    (ack_i[i]),
            .pend   (pend[i])
        );
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && out_of_window;
        if (req_valid && !req_write && !IS_SUP) begin
            rsp_d.rdata[0] = |(pend & slot_hit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;
    assign irq_o     = pend;

    a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r4_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r5_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));
    a_r5_err_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && out_of_window && !(|ack_i)) |=> $stable(irq_o));
    a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[31:1] == '0));
    if (IS_SUP) begin : g_sup_read_chk
        a_r7_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid |-> (rsp_rdata == '0));
    end
endmodule

// File: tb/soft_irq_unit_bench.sv
module soft_irq_unit_bench;
    import sirq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  ack = '0;

    logic        m_vld, m_err, s_vld, s_err;
    logic [31:0] m_rd, s_rd;
    logic [3:0]  m_irq, s_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    soft_irq_unit #(.ADDR_W(16), .N_HART(4), .FLAVOUR(FLAVOUR_MACHINE)) u_soft_irq_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(m_vld),
        .rsp_rdata(m_rd), .rsp_err(m_err), .ack_i(ack), .irq_o(m_irq));

    soft_irq_unit #(.ADDR_W(16), .N_HART(4), .FLAVOUR(FLAVOUR_SUPERVISOR)) u_soft_irq_unit_sup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(s_vld),
        .rsp_rdata(s_rd), .rsp_err(s_err), .ack_i(ack), .irq_o(s_irq));

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        err;
        logic [3:0]  irq;
    } vec_t;

    localparam int N_VEC = 14;
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 16'h0000, 32'hFFFF_FFFE, 32'h0, 1'b0, 4'b0000},
        '{1'b1, 16'h0004, 32'h0000_0003, 32'h0, 1'b0, 4'b0010},
        '{1'b0, 16'h0004, 32'h0,         32'h1, 1'b0, 4'b0010},
        '{1'b0, 16'h0000, 32'h0,         32'h0, 1'b0, 4'b0010},
        '{1'b1, 16'h000C, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b1010},
        '{1'b0, 16'h000C, 32'h0,         32'h1, 1'b0, 4'b1010},
        '{1'b1, 16'h0010, 32'h1,         32'h0, 1'b0, 4'b1010},
        '{1'b0, 16'h0010, 32'h0,         32'h0, 1'b0, 4'b1010},
        '{1'b1, 16'h4000, 32'h1,         32'h0, 1'b1, 4'b1010},
        '{1'b0, 16'h4000, 32'h0,         32'h0, 1'b1, 4'b1010},
        '{1'b1, 16'h3FFC, 32'h1,         32'h0, 1'b0, 4'b1010},
        '{1'b1, 16'h0004, 32'h0,         32'h0, 1'b0, 4'b1000},
        '{1'b0, 16'h0004, 32'h0,         32'h0, 1'b0, 4'b1000},
        '{1'b1, 16'h8004, 32'h1,         32'h0, 1'b1, 4'b1000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 m_irq", 32'(m_irq), 32'h0);
        chk("R1 s_irq", 32'(s_irq), 32'h0);
        chk("R1 rsp_valid", 32'(m_vld), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle rsp_valid", 32'(m_vld), 32'h0);

        // Table walk: R2 R3 R5 R6 on machine flavour, R7 on supervisor reads
        for (int k = 0; k < N_VEC; k++) begin
            access(VECS[k].wr, VECS[k].addr, VECS[k].wdata);
            chk($sformatf("R4 vec%0d valid", k), 32'(m_vld), 32'h1);
            chk($sformatf("R3/R6 vec%0d rdata", k), m_rd, VECS[k].rdata);
            chk($sformatf("R5 vec%0d err", k), 32'(m_err), 32'(VECS[k].err));
            chk($sformatf("R2 vec%0d irq", k), 32'(m_irq), 32'(VECS[k].irq));
            chk($sformatf("R7 vec%0d sup rdata", k), s_rd, 32'h0);
        end
        @(negedge clk);
        chk("R4 pulse ends", 32'(m_vld), 32'h0);

        // R10: acknowledge does not touch machine pending bits (bit3 set)
        ack = 4'b1111;
        @(negedge clk);
        ack = 4'b0000;
        @(negedge clk);
        chk("R10 m_irq after ack", 32'(m_irq), 32'h8);

        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 m_irq after reset", 32'(m_irq), 32'h0);
        rst_n = 1'b1;

        // R8 supervisor set
        access(1'b1, 16'h0008, 32'h1);
        chk("R8 s_irq set", 32'(s_irq), 32'h4);
        chk("R7 s write rdata", s_rd, 32'h0);
        access(1'b1, 16'h0008, 32'hFFFF_FFFE);
        chk("R8 zero write no effect", 32'(s_irq), 32'h4);
        access(1'b0, 16'h0008, 32'h0);
        chk("R7 s read zero while pending", s_rd, 32'h0);
        chk("R3 m read slot2", m_rd, 32'h0);

        // R9 acknowledge clears
        @(negedge clk); ack = 4'b0100;
        @(negedge clk); ack = 4'b0000;
        chk("R9 ack clears", 32'(s_irq), 32'h0);

        // R9 set and acknowledge together: set wins
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0004; req_wdata = 32'h1;
        ack = 4'b0010;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; ack = 4'b0000;
        chk("R9 set wins", 32'(s_irq), 32'h2);

        // R5 out of window on supervisor
        access(1'b1, 16'h4008, 32'h1);
        chk("R5 s err", 32'(s_err), 32'h1);
        chk("R5 s no set", 32'(s_irq), 32'h2);
        // R6 beyond N_HART on supervisor
        access(1'b1, 16'h0014, 32'h1);
        chk("R6 s err", 32'(s_err), 32'h0);
        chk("R6 s no set", 32'(s_irq), 32'h2);
        chk("R4 s valid", 32'(s_vld), 32'h1);

        finish_run();
    end
endmodule